// File: doc/BRIEF.md
# Watchdog and Undervoltage Reset Supervisor

This block supervises a host processor that sits behind a voltage regulator. It drives an active-low system reset and an enable line for the regulator output. The host shows it is alive by toggling a watchdog pin. An already-digitised power-good flag reports whether the rail is in regulation. A separate enable input forces the regulator on regardless of the watchdog.

After reset or after an undervoltage, the system reset is held low for a power-on delay. While watchdog edges are missing and the enable input is high, the reset line carries a square pulse train. If the enable input is low while the watchdog has timed out, the regulator is switched off and the block goes to sleep. In sleep only the enable input is obeyed.

One base tick sets all the timing. The watchdog timeout, the reset pulse width and the power-on delay are 130, 100 and 475 base ticks by default. The undervoltage filter length is a separate parameter.

Top module: `supv_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_no` is 0 and `reg_en_o` is 1. The controller sits in state ST_POR with its phase counter cleared.
- R2: The default timing derives from `BASE_TICK` in fixed ratios: timeout TO = 130·BASE_TICK, pulse width PW = 100·BASE_TICK and power-on delay PD = 475·BASE_TICK clock cycles.
- R3: When `en_i` is high at a clock edge, `reg_en_o` is 1 after that edge, whatever the watchdog state.
- R4: With `en_i` low and watchdog rising edges arriving closer than TO cycles apart, `reg_en_o` stays 1 and `sys_rst_no` stays 1.
- R5: A watchdog edge is a rising edge of `wdog_i` after a two-flop synchroniser, and each edge restarts the timeout. If `wdog_i` rises once and then stays static, the outputs react to the timeout after clock edge TO+4, counted from the first edge after the rise.
- R6: Transition RUN/POR/PULSE→SLEEP happens when `en_i` is low and the watchdog has timed out. In ST_SLEEP, `reg_en_o` and `sys_rst_no` are 0, and watchdog edges and power-good are ignored. Transition SLEEP→POR happens on the first edge with `en_i` high, and `sys_rst_no` then rises PD+1 edges after `en_i` rose.
- R7: Transition RUN→PULSE_LO happens when the timeout expires with `en_i` high. ST_PULSE_LO (reset 0) and ST_PULSE_HI (reset 1) each last PW cycles and alternate. Transition PULSE→RUN happens as soon as the timeout clears.
- R8: If `pgood_i` is low for UV_TICKS consecutive cycles, an undervoltage fault is raised. The fault forces ST_POR and `sys_rst_no` low on the following edge, from any state except ST_SLEEP. A shorter low period in ST_RUN has no effect on the outputs.
- R9: Transition POR→RUN happens only when `pgood_i` is high, PD cycles have been counted and the watchdog is not timed out. Every cycle with `pgood_i` low clears the power-on count. After reset release, `sys_rst_no` rises at edge PD. After a low period shorter than the filter, it rises PD edges after `pgood_i` returns. After a fault, it rises PD+1 edges after `pgood_i` returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low block reset |
| wdog_i | input | 1 | Watchdog toggle from the host (asynchronous) |
| pgood_i | input | 1 | Regulation-good flag, 1 = in regulation |
| en_i | input | 1 | Enable; high keeps the regulator on |
| sys_rst_no | output | 1 | Registered active-low system reset |
| reg_en_o | output | 1 | Regulator output enable, 0 = sleep |

## Verification
The bench builds the block with BASE_TICK = 1 and UV_TICKS = 50. This gives a 130-cycle timeout, 100-cycle pulse phases and a 475-cycle power-on delay. At these values one run can cover the full power-on delay, several pulse-train phases, an undervoltage fault with its restart, a delay held off by a dead watchdog, and a sleep entry and wake. Exact edge-cycle checks count the synchroniser, the counters and the output register.

// File: rtl/supv_pkg.sv
package supv_pkg;
    typedef enum logic [2:0] {
        ST_POR      = 3'd0,
        ST_RUN      = 3'd1,
        ST_PULSE_LO = 3'd2,
        ST_PULSE_HI = 3'd3,
        ST_SLEEP    = 3'd4
    } supv_state_e;
endpackage

// File: rtl/supv_wdog_mon.sv
module supv_wdog_mon #(
    parameter int TO_TICKS = 130
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wdog_i,
    input  logic hold_i,
    output logic late_o
);
    localparam int CW = $clog2(TO_TICKS + 1);

    logic          s1_q, s2_q, s3_q;
    logic          edge_w;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= wdog_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign edge_w = s2_q & ~s3_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (hold_i) begin
            cnt_q <= CW'(TO_TICKS);
        end else if (edge_w) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(TO_TICKS)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign late_o = (cnt_q == CW'(TO_TICKS));

    // R5
    edge_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_w && !hold_i) |=> !late_o);

    // R5
    late_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (late_o && !edge_w) |=> late_o);
endmodule

// File: rtl/supv_uv_filter.sv
module supv_uv_filter #(
    parameter int UV_TICKS = 250000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pgood_i,
    output logic fault_o
);
    localparam int UW = $clog2(UV_TICKS + 1);

    logic [UW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (pgood_i) begin
            cnt_q <= '0;
        end else if (cnt_q != UW'(UV_TICKS)) begin
            cnt_q <= cnt_q + UW'(1);
        end
    end

    assign fault_o = (cnt_q == UW'(UV_TICKS));

    // R8
    good_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pgood_i |=> !fault_o);
endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
    import supv_pkg::*;
#(
    parameter int BASE_TICK    = 1000,
    parameter int TO_TICKS     = 130 * BASE_TICK,
    parameter int PULSE_TICKS  = 100 * BASE_TICK,
    parameter int POR_TICKS    = 475 * BASE_TICK,
    parameter int UV_TICKS     = 250000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wdog_i,
    input  logic pgood_i,
    input  logic en_i,
    output logic sys_rst_no,
    output logic reg_en_o
);
    localparam int PH_MAX = (POR_TICKS > PULSE_TICKS) ? POR_TICKS : PULSE_TICKS;
    localparam int PW     = $clog2(PH_MAX + 1);

    supv_state_e   state_q, st_d;
    logic [PW-1:0] ph_q, ph_d;
    logic          wd_late;
    logic          uv_fault;
    logic          rst_q, en_q;

    supv_wdog_mon #(.TO_TICKS(TO_TICKS)) wdog_i0 (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wdog_i (wdog_i),
        .hold_i (state_q == ST_SLEEP),
        .late_o (wd_late)
    );

    supv_uv_filter #(.UV_TICKS(UV_TICKS)) uv_i0 (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pgood_i (pgood_i),
        .fault_o (uv_fault)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_POR;
            ph_q    <= '0;
        end else begin
            state_q <= st_d;
            ph_q    <= ph_d;
        end
    end

    always_comb begin
        st_d = state_q;
        ph_d = ph_q;
        if (state_q != ST_SLEEP && !en_i && wd_late) begin
            st_d = ST_SLEEP;
            ph_d = '0;
        end else if (state_q != ST_SLEEP && uv_fault) begin
            st_d = ST_POR;
            ph_d = '0;
        end else begin
            unique case (state_q)
                ST_POR: begin
                    if (!pgood_i) begin
                        ph_d = '0;
                    end else if (ph_q == PW'(POR_TICKS - 1)) begin
                        if (!wd_late) begin
                            st_d = ST_RUN;
                            ph_d = '0;
                        end
                    end else begin
                        ph_d = ph_q + PW'(1);
                    end
                end
                ST_RUN: begin
                    if (wd_late) begin
                        st_d = ST_PULSE_LO;
                        ph_d = '0;
                    end
                end
                ST_PULSE_LO: begin
                    if (!wd_late) begin
                        st_d = ST_RUN;
                        ph_d = '0;
                    end else if (ph_q == PW'(PULSE_TICKS - 1)) begin
                        st_d = ST_PULSE_HI;
                        ph_d = '0;
                    end else begin
                        ph_d = ph_q + PW'(1);
                    end
                end
                ST_PULSE_HI: begin
                    if (!wd_late) begin
                        st_d = ST_RUN;
                        ph_d = '0;
                    end else if (ph_q == PW'(PULSE_TICKS - 1)) begin
                        st_d = ST_PULSE_LO;
                        ph_d = '0;
                    end else begin
                        ph_d = ph_q + PW'(1);
                    end
                end
                ST_SLEEP: begin
                    if (en_i) begin
                        st_d = ST_POR;
                        ph_d = '0;
                    end
                end
                default: begin
                    st_d = ST_POR;
                    ph_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rst_q <= 1'b0;
            en_q  <= 1'b1;
        end else begin
            rst_q <= (st_d == ST_RUN) || (st_d == ST_PULSE_HI);
            en_q  <= (st_d != ST_SLEEP);
        end
    end

    assign sys_rst_no = rst_q;
    assign reg_en_o   = en_q;

    // R3
    enable_forces_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> reg_en_o);

    // R6
    sleep_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SLEEP && !en_i) |=> (!reg_en_o && !sys_rst_no));

    // R8
    uv_forces_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (uv_fault && state_q != ST_SLEEP) |=> !sys_rst_no);

    // R9
    por_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(sys_rst_no) && $past(state_q) == ST_POR) |-> ($past(pgood_i) && !$past(wd_late)));
endmodule

// File: tb/supv_ctrl_tb_top.sv
module supv_ctrl_tb_top;
    localparam int BASE = 1;
    localparam int UV   = 50;
    localparam int TO   = 130 * BASE;
    localparam int PU   = 100 * BASE;
    localparam int PD   = 475 * BASE;

    logic clk = 1'b0;
    logic rst_n, wdog, pgood, en;
    logic sys_rst_n, reg_en;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   wd_run = 1'b0;
    int   last_rise = 0;
    int   exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    supv_ctrl #(.BASE_TICK(BASE), .UV_TICKS(UV)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wdog_i(wdog), .pgood_i(pgood),
        .en_i(en), .sys_rst_no(sys_rst_n), .reg_en_o(reg_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // watchdog toggler: 40-cycle period
    initial begin
        wdog = 1'b0;
        forever begin
            @(negedge clk);
            if (wd_run) begin
                wdog = 1'b1;
                last_rise = cyc;
                repeat (20) @(negedge clk);
                wdog = 1'b0;
                repeat (19) @(negedge clk);
            end
        end
    end

    // scoreboard monitor: phase lengths of the reset line
    initial begin
        logic prev;
        int   chg;
        prev = 1'b0;
        chg  = 0;
        forever begin
            @(negedge clk);
            if (sys_rst_n !== prev) begin
                if (exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    chk((cyc - chg) == e, "R7 pulse phase", cyc - chg, e);
                end
                prev = sys_rst_n;
                chg  = cyc;
            end
        end
    end

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int m;
        int f;
        rst_n = 1'b0; en = 1'b1; pgood = 1'b1; wd_run = 1'b1;
        repeat (5) @(negedge clk);
        // R1
        chk(sys_rst_n == 1'b0, "R1 reset low", sys_rst_n, 0);
        chk(reg_en == 1'b1, "R1 enable high", reg_en, 1);

        // R9 / R2 power-on delay
        @(negedge clk); rst_n = 1'b1; m = cyc;
        wait_until(m + PD - 1);
        chk(sys_rst_n == 1'b0, "R9 POR still low", sys_rst_n, 0);
        @(negedge clk);
        chk(sys_rst_n == 1'b1, "R2 POR releases at PD", sys_rst_n, 1);

        // R4 enable low, watchdog healthy
        en = 1'b0;
        repeat (300) @(negedge clk);
        chk(reg_en == 1'b1, "R4 regulator on", reg_en, 1);
        chk(sys_rst_n == 1'b1, "R4 reset high", sys_rst_n, 1);
        en = 1'b1;

        // R8 short dip ignored
        @(negedge clk); pgood = 1'b0;
        repeat (25) @(negedge clk);
        pgood = 1'b1;
        repeat (5) @(negedge clk);
        chk(sys_rst_n == 1'b1, "R8 short dip ignored", sys_rst_n, 1);

        // R8 long undervoltage
        pgood = 1'b0; m = cyc;
        wait_until(m + UV);
        chk(sys_rst_n == 1'b1, "R8 before filter", sys_rst_n, 1);
        @(negedge clk);
        chk(sys_rst_n == 1'b0, "R8 fault forces reset", sys_rst_n, 0);
        repeat (10) @(negedge clk);
        pgood = 1'b1; m = cyc;
        wait_until(m + PD);
        chk(sys_rst_n == 1'b0, "R9 delay after fault", sys_rst_n, 0);
        @(negedge clk);
        chk(sys_rst_n == 1'b1, "R9 release after fault", sys_rst_n, 1);

        // R5 timeout and R7 pulse train
        @(posedge clk); wd_run = 1'b0;
        f = 0;
        for (int i = 0; i < 400 && f == 0; i++) begin
            @(negedge clk);
            if (sys_rst_n == 1'b0) f = cyc;
        end
        chk(f == last_rise + TO + 4, "R5 timeout cycle", f, last_rise + TO + 4);
        @(posedge clk);
        exp_q.push_back(PU); exp_q.push_back(PU); exp_q.push_back(PU);
        for (int i = 0; i < 400 && exp_q.size() > 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, "R7 train phases seen", exp_q.size(), 0);
        chk(reg_en == 1'b1, "R3 enable keeps regulator on", reg_en, 1);

        // R9 delay held while watchdog invalid
        pgood = 1'b0;
        repeat (60) @(negedge clk);
        pgood = 1'b1;
        repeat (PD + 50) @(negedge clk);
        chk(sys_rst_n == 1'b0, "R9 held by dead watchdog", sys_rst_n, 0);
        @(posedge clk); wd_run = 1'b1;
        f = 0;
        for (int i = 0; i < 80 && f == 0; i++) begin
            @(negedge clk);
            if (sys_rst_n == 1'b1) f = 1;
        end
        chk(f == 1, "R9 release on valid watchdog", f, 1);

        // R9 any low cycle restarts the delay
        pgood = 1'b0;
        repeat (60) @(negedge clk);
        pgood = 1'b1;
        repeat (100) @(negedge clk);
        pgood = 1'b0;
        repeat (3) @(negedge clk);
        pgood = 1'b1; m = cyc;
        wait_until(m + PD - 1);
        chk(sys_rst_n == 1'b0, "R9 restarted delay", sys_rst_n, 0);
        @(negedge clk);
        chk(sys_rst_n == 1'b1, "R9 restarted release", sys_rst_n, 1);

        // R6 sleep
        en = 1'b0;
        @(posedge clk); wd_run = 1'b0;
        f = 0;
        for (int i = 0; i < 400 && f == 0; i++) begin
            @(negedge clk);
            if (reg_en == 1'b0) f = cyc;
        end
        chk(f == last_rise + TO + 4, "R6 sleep entry cycle", f, last_rise + TO + 4);
        chk(sys_rst_n == 1'b0, "R6 reset low in sleep", sys_rst_n, 0);
        @(posedge clk); wd_run = 1'b1;
        repeat (200) @(negedge clk);
        chk(reg_en == 1'b0, "R6 watchdog ignored in sleep", reg_en, 0);
        pgood = 1'b0;
        repeat (60) @(negedge clk);
        pgood = 1'b1;
        repeat (3) @(negedge clk);
        chk(reg_en == 1'b0, "R6 pgood ignored in sleep", reg_en, 0);
        en = 1'b1; m = cyc;
        @(negedge clk);
        chk(reg_en == 1'b1, "R3 wake enables regulator", reg_en, 1);
        wait_until(m + PD);
        chk(sys_rst_n == 1'b0, "R6 wake delay", sys_rst_n, 0);
        @(negedge clk);
        chk(sys_rst_n == 1'b1, "R6 wake release", sys_rst_n, 1);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule